// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Gated, Event and Output Modes

The block is an 8-bit down-counter fed by a 7-bit prescaler. A processor reaches it through three byte-wide registers on a simple register bus: a control/status register, the counter, and the prescaler. The prescaler is read-only. The prescaler counts one of two things:
- an internal timing strobe supplied from outside (`tick_strobe`), or
- activity on the timer pin.

A 3-bit select field decides how many prescaler counts make one counter step. When the counter steps from 01h to 00h, a sticky zero flag is raised. If the interrupt enable is set, an interrupt request follows.

A small state machine decodes the control bits into one of four counting states:
- `ST_HALT`: run bit clear, nothing counts.
- `ST_GATE`: the strobe counts only while the synchronised pin is high. This is used to measure pulse widths.
- `ST_EVENT`: each synchronised rising edge of the pin counts.
- `ST_DRIVE`: the strobe counts, and the pin is an output.

The state follows the control register as it is written. The transitions are:
- `GO_HALT` when the run bit is written 0.
- `GO_DRIVE` when the run and drive bits are written 1.
- `GO_GATE` when run is written 1, drive 0 and the data bit 1.
- `GO_EVENT` when run is written 1 and both the drive and data bits are 0.

In the drive state, a low-to-high change of the zero flag copies the data bit into the pin latch, so software can generate a waveform on the pin.

Top module: `dcnt_timer`

## Requirements
- R1: Asynchronous active-low reset sets the control register to 00h, the counter to FFh, the prescaler to 7Fh, the pin latch to 0 and `irq` to 0.
- R2: Reads are combinational. Address 0 returns the control register, laid out as bit 7 zero flag, bit 6 interrupt enable, bit 5 drive, bit 4 data, bit 3 run, bits 2:0 prescaler select. Address 1 returns the counter, address 2 returns {0, prescaler}, and address 3 returns 00h.
- R3: With the run bit 0, neither the counter nor the prescaler changes, whatever the strobe and pin do.
- R4: Each count enable decrements the 7-bit prescaler, which wraps from 00h to 7Fh. A counter step happens on a count enable whose pre-decrement prescaler value has its low PS bits all zero. This gives one step per 2^PS counts.
- R5: Drive state (run 1, bit 5 = 1): the strobe is the count enable and `pin_oe` is 1.
- R6: Gate state (run 1, bit 5 = 0, bit 4 = 1): the strobe counts only while the synchronised pin is 1, and `pin_oe` is 0.
- R7: Event state (run 1, bits 5 and 4 = 0): each rising edge of the two-flop-synchronised pin is one count enable, and the strobe has no effect.
- R8: A counter step subtracts one. A step from 00h gives FFh and does not set the zero flag.
- R9: The zero flag is set in three ways:
  - a step from 01h to 00h;
  - a write of 00h to the counter;
  - a write of 1 to bit 7.

  A write of 0 to bit 7 clears it, but a hardware set in the same cycle wins.
- R10: A counter write in the same cycle as a step loads the written value. A step from 01h that coincides with a non-zero write does not set the flag.
- R11: `irq` is 1 exactly while both the zero flag and the interrupt enable are 1.
- R12: `pin_out` shows the pin latch. In the drive state, the clock edge on which the zero flag rises loads the data bit into the latch. The latch holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_strobe | input | 1 | Internal timing strobe, one clock wide per pulse |
| pin_in | input | 1 | Timer pin input, asynchronous |
| pin_out | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 7-bit prescaler and a two-stage pin synchroniser. With these values, the prescaler's full range is short enough to step through. Divide-by-1 and divide-by-4 runs, together with the prescaler readback, show where the tap boundary falls.

The bench walks through all four counting states. It also covers:
- the 00h-to-FFh wrap;
- each way the flag can be set and cleared;
- a counter write colliding with a step to zero;
- a clearing flag write colliding with a hardware set.

// File: rtl/dcnt_timer_pkg.sv
package dcnt_timer_pkg;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PSC  = 2'd2;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       drive;
        logic       dout;
        logic       run;
        logic [2:0] ps;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_GATE  = 2'd1,
        ST_EVENT = 2'd2,
        ST_DRIVE = 2'd3
    } cnt_state_t;

endpackage

// File: rtl/dcnt_pin_sync.sv
module dcnt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_lvl,
    output logic pin_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_raw};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign pin_lvl  = sync_q[STAGES-1];
    assign pin_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dcnt_prescaler.sv
module dcnt_prescaler #(
    parameter int PSC_W = 7,
    parameter int SEL_W = $clog2(PSC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [SEL_W-1:0] sel,
    output logic [PSC_W-1:0] value,
    output logic             step
);
    localparam logic [PSC_W-1:0] RST_VAL = {PSC_W{1'b1}};

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] tap_mask;

    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            tap_mask[i] = (i < int'(sel));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= RST_VAL;
        end else if (cnt_en) begin
            psc_q <= psc_q - 1'b1;
        end
    end

    assign value = psc_q;
    assign step  = cnt_en && ((psc_q & tap_mask) == '0);
endmodule

// File: rtl/dcnt_counter.sv
module dcnt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] value,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // a load in the same cycle wins and suppresses the zero event
    assign value    = cnt_q;
    assign hit_zero = step && !load && (cnt_q == ONE);
endmodule

// File: rtl/dcnt_mode_fsm.sv
module dcnt_mode_fsm
    import dcnt_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_d,
    input  logic       drive_d,
    input  logic       dout_d,
    input  logic       strobe,
    input  logic       pin_lvl,
    input  logic       pin_rise,
    output cnt_state_t state,
    output logic       cnt_en
);
    cnt_state_t state_q;
    cnt_state_t state_d;

    always_comb begin
        if (!run_d) begin
            state_d = ST_HALT;
        end else if (drive_d) begin
            state_d = ST_DRIVE;
        end else if (dout_d) begin
            state_d = ST_GATE;
        end else begin
            state_d = ST_EVENT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cnt_en = 1'b0;
        unique case (state_q)
            ST_HALT:  cnt_en = 1'b0;
            ST_GATE:  cnt_en = strobe & pin_lvl;
            ST_EVENT: cnt_en = pin_rise;
            ST_DRIVE: cnt_en = strobe;
            default:  cnt_en = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
    import dcnt_timer_pkg::*;
#(
    parameter int PSC_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_strobe,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int SEL_W = $clog2(PSC_W + 1);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_d;
    logic [7:0]       ctrl_bits;
    logic [CNT_W-1:0] cnt_val;
    logic [PSC_W-1:0] psc_val;
    logic             pin_q;
    logic             pin_lvl;
    logic             pin_rise;
    logic             cnt_en;
    logic             step;
    logic             hit_zero;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic             wr_zero;
    cnt_state_t       state;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
    assign wr_zero = cnt_wr && (bus_wdata == '0);

    dcnt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_lvl  (pin_lvl),
        .pin_rise (pin_rise)
    );

    dcnt_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_d    (ctrl_d.run),
        .drive_d  (ctrl_d.drive),
        .dout_d   (ctrl_d.dout),
        .strobe   (tick_strobe),
        .pin_lvl  (pin_lvl),
        .pin_rise (pin_rise),
        .state    (state),
        .cnt_en   (cnt_en)
    );

    dcnt_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .sel    (ctrl_q.ps[SEL_W-1:0]),
        .value  (psc_val),
        .step   (step)
    );

    dcnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (cnt_wr),
        .load_val (bus_wdata),
        .value    (cnt_val),
        .hit_zero (hit_zero)
    );

    // control register next value; hardware flag sets win over a clearing write
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d = ctrl_t'(bus_wdata);
        end
        ctrl_d.flag = (ctrl_wr ? bus_wdata[7] : ctrl_q.flag) | hit_zero | wr_zero;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pin_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            if (ctrl_d.drive && ctrl_d.flag && !ctrl_q.flag) begin
                pin_q <= ctrl_d.dout;
            end
        end
    end

    assign ctrl_bits = ctrl_q;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_bits;
            A_CNT:   bus_rdata = cnt_val;
            A_PSC:   bus_rdata = DATA_W'(psc_val);
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = pin_q;
    assign pin_oe  = ctrl_q.drive;
    assign irq     = ctrl_q.flag & ctrl_q.ie;
endmodule

// File: rtl/dcnt_timer_chk.sv
module dcnt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] ctrl_bits,
    input logic [7:0] cnt_val,
    input logic [6:0] psc_val,
    input logic       pin_out
);
    logic cnt_wr;
    logic ctrl_wr;
    assign cnt_wr  = bus_wr && (bus_addr == 2'd1);
    assign ctrl_wr = bus_wr && (bus_addr == 2'd0);

    a_r3_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[3] && !cnt_wr) |=> ($stable(cnt_val) && $stable(psc_val)));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_val == $past(bus_wdata)));

    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((cnt_val == $past(cnt_val)) || (cnt_val == $past(cnt_val) - 8'd1)));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[7] && !ctrl_wr) |=> ctrl_bits[7]);

    a_r12_pin_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out != $past(pin_out)) |-> $rose(ctrl_bits[7]));
endmodule

bind dcnt_timer dcnt_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_bits (ctrl_bits),
    .cnt_val   (cnt_val),
    .psc_val   (psc_val),
    .pin_out   (pin_out)
);

// File: tb/test_dcnt_timer.sv
module test_dcnt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_strobe = 1'b0;
    logic       pin_in = 1'b0;
    logic       pin_out;
    logic       pin_oe;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // kinds: 0..3 register address, 4 irq, 5 pin_out, 6 pin_oe
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    dcnt_timer i_dcnt_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_strobe (tick_strobe),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq         (irq)
    );

    // monitor: compare each expected item against the design at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                4:       act = {7'd0, irq};
                5:       act = {7'd0, pin_out};
                6:       act = {7'd0, pin_oe};
                default: act = bus_rdata;
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fails++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        if (kind < 4) bus_addr = kind[1:0];
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic pin_pulse();
        pin_in = 1'b1;
        repeat (3) tick();
        pin_in = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state, R2 map
        expect_item(0, 8'h00, "R1");
        expect_item(1, 8'hFF, "R1");
        expect_item(2, 8'h7F, "R1");
        expect_item(4, 8'h00, "R1");
        expect_item(6, 8'h00, "R1");
        expect_item(3, 8'h00, "R2");

        // drive state, divide by 1
        wr(2'd0, 8'h38);
        expect_item(6, 8'h01, "R5");
        expect_item(5, 8'h00, "R12");
        wr(2'd1, 8'h05);
        tick_strobe = 1'b1;
        repeat (3) tick();
        tick_strobe = 1'b0;
        expect_item(1, 8'h02, "R5");
        expect_item(2, 8'h7C, "R4");
        tick_strobe = 1'b1;
        repeat (2) tick();
        tick_strobe = 1'b0;
        expect_item(1, 8'h00, "R8");
        expect_item(0, 8'hB8, "R9");
        expect_item(5, 8'h01, "R12");
        expect_item(4, 8'h00, "R11");

        // divide by 4
        wr(2'd0, 8'h2A);
        wr(2'd1, 8'h10);
        tick_strobe = 1'b1;
        repeat (8) tick();
        tick_strobe = 1'b0;
        expect_item(1, 8'h0E, "R4");
        expect_item(2, 8'h72, "R4");
        expect_item(5, 8'h01, "R12");

        // gate state
        wr(2'd0, 8'h18);
        expect_item(6, 8'h00, "R6");
        wr(2'd1, 8'h20);
        tick_strobe = 1'b1;
        repeat (4) tick();
        tick_strobe = 1'b0;
        expect_item(1, 8'h20, "R6");
        pin_in = 1'b1;
        repeat (3) tick();
        tick_strobe = 1'b1;
        repeat (4) tick();
        tick_strobe = 1'b0;
        expect_item(1, 8'h1C, "R6");
        pin_in = 1'b0;
        repeat (3) tick();

        // event state, strobe held high
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h03);
        tick_strobe = 1'b1;
        for (int k = 0; k < 3; k++) pin_pulse();
        tick_strobe = 1'b0;
        expect_item(1, 8'h00, "R7");
        expect_item(0, 8'h88, "R9");
        wr(2'd0, 8'hC8);
        expect_item(4, 8'h01, "R11");
        wr(2'd0, 8'h48);
        expect_item(4, 8'h00, "R11");
        expect_item(0, 8'h48, "R9");
        pin_pulse();
        expect_item(1, 8'hFF, "R8");
        expect_item(0, 8'h48, "R8");
        wr(2'd1, 8'h00);
        expect_item(0, 8'hC8, "R9");
        expect_item(4, 8'h01, "R11");
        wr(2'd0, 8'h08);

        // write versus step to zero
        wr(2'd0, 8'h28);
        wr(2'd1, 8'h01);
        tick_strobe = 1'b1;
        bus_addr = 2'd1; bus_wdata = 8'h40; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        tick_strobe = 1'b0;
        expect_item(1, 8'h40, "R10");
        expect_item(0, 8'h28, "R10");
        expect_item(5, 8'h01, "R12");
        wr(2'd1, 8'h01);
        tick_strobe = 1'b1;
        tick();
        tick_strobe = 1'b0;
        expect_item(0, 8'hA8, "R9");
        expect_item(5, 8'h00, "R12");

        // hardware set beats a clearing write
        wr(2'd0, 8'h28);
        wr(2'd1, 8'h01);
        tick_strobe = 1'b1;
        bus_addr = 2'd0; bus_wdata = 8'h28; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        tick_strobe = 1'b0;
        expect_item(0, 8'hA8, "R9");

        // halted
        wr(2'd0, 8'h20);
        wr(2'd1, 8'h33);
        tick_strobe = 1'b1;
        pin_pulse();
        tick_strobe = 1'b0;
        expect_item(1, 8'h33, "R3");
        expect_item(6, 8'h01, "R3");

        tick();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule